// File: doc/BRIEF.md
# Programmable Memory Chip-Select Unit

This block turns the 20-bit physical address of each bus cycle into active-low chip selects for three memory regions. The upper region always ends at the top of the 1-Mbyte space, the lower region always starts at address zero, and a midrange block that software places anywhere else is split into four equal quarter selects. Each region carries its own wait-state count (0 to 3) and a flag saying whether the cycle must also wait for an external ready input.

A bus master pulses `cyc_start` with the cycle address. From the next clock the unit drives at most one select low, presents the wait count and ready mode that govern that cycle, and raises `cyc_done` in the clock where the cycle may end. The selects return high on the clock after `cyc_done`. When more than one region matches an address, the select goes to the region with the highest priority, but every matching region's timing still applies. The wait count is the largest of them, and ready is required if any of them requires it, so mismatched settings slow the cycle down but never make it hang. The upper region is usable straight out of reset. The lower and midrange regions stay silent until software writes their register.

Four 16-bit registers are written through `cfg_we`, `cfg_sel` and `cfg_wdata`:
- **Select 0, upper region:** bits [1:0] size code k, bits [5:4] wait count, bit 6 ready required.
- **Select 1, lower region:** the same layout as select 0.
- **Select 2, midrange block:** bits [1:0] size code k, bit 3 single-select mode, bits [5:4] wait count, bit 6 ready required, bits [15:9] base address bits [19:13].
- **Select 3, bus width:** bit 0 gives a 16-bit lower region, bit 1 gives a 16-bit midrange block.

Top module: `memsel_unit`

## Requirements
- R1: After reset every select is high, `bot_wide` and `mid_wide` are 0, and the upper region covers F0000h to FFFFFh with 3 wait states and ready required.
- R2: The upper region spans from 100000h minus (64 Kbytes << k) up to FFFFFh, where k is bits [1:0] of register 0.
- R3: The lower region spans from 00000h up to (64 Kbytes << k) - 1, with k taken from bits [1:0] of register 1. It matches nothing until register 1 has been written once.
- R4: The midrange block is (8 Kbytes << k) long, with k taken from bits [1:0] of register 2. It is aligned to its own size, with the base given by bits [15:9] of register 2 as address bits [19:13]. Quarter q of the block, counted upward from the base, drives `mid_cs_n[q]`. The block matches nothing until register 2 has been written once.
- R5: With bit 3 of register 2 set, `mid_cs_n[0]` covers the whole midrange block and `mid_cs_n[3:1]` never go low.
- R6: At most one select is low at any time. The priority is upper, then lower, then midrange.
- R7: A cycle's `cyc_wait` is the largest wait count among all enabled regions the address falls in. Its `cyc_rdy_req` is the OR of their ready-required bits, even when a region's select loses on priority.
- R8: The selects take their values on the clock after the clock that samples `cyc_start`. With ready not required, a cycle lasts `cyc_wait`+1 clocks including the `cyc_done` clock, and all selects are high on the clock after `cyc_done`.
- R9: With ready required, `cyc_done` is asserted only once the wait count has expired and `rdy_in` is high. Until then the cycle holds.
- R10: `bot_wide` follows bit 0 and `mid_wide` follows bit 1 of register 3.
- R11: A `cyc_start` pulse during an active cycle is ignored. The selects stay unchanged and the cycle length is unaffected.
- R12: An address in no enabled region drives no select and gives a cycle with wait 0, ready not required, that lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 upper, 1 lower, 2 midrange, 3 width) |
| cfg_wdata | input | 16 | Register write data |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_addr | input | 20 | Bus cycle address, valid with `cyc_start` |
| rdy_in | input | 1 | External ready |
| top_cs_n | output | 1 | Upper region select, active low |
| bot_cs_n | output | 1 | Lower region select, active low |
| mid_cs_n | output | 4 | Midrange quarter selects, active low |
| cyc_wait | output | 2 | Wait count in force for the current cycle |
| cyc_rdy_req | output | 1 | External ready required for the current cycle |
| cyc_done | output | 1 | The current cycle ends on this clock |
| bot_wide | output | 1 | Lower region bus is 16 bits wide |
| mid_wide | output | 1 | Midrange bus is 16 bits wide |

## Verification
The bench tests the region edges on both sides of each limit: E0000h against DFFFFh, 0FFFFh against 10000h, and each midrange quarter together with the addresses just outside the block. A decoder with an off-by-one mask or the wrong quarter bits would assert the wrong select there. It sends cycles to the lower and midrange addresses before those registers are written, which catches a design that enables them from reset. It places a slow midrange block inside the upper region and checks that the upper select wins while the slower timing still rules. A design that takes timing only from the winning region would end that cycle early. It also holds ready low past the wait count, and pulses a second start in the middle of a cycle, to show the cycle neither ends early nor restarts.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

   localparam int CFG_W   = 16;
   localparam int WAIT_W  = 2;
   localparam int SIZE_W  = 2;
   localparam int NSEL    = 6;   // upper, lower, four midrange quarters

   localparam logic [1:0] SEL_TOP  = 2'd0;
   localparam logic [1:0] SEL_BOT  = 2'd1;
   localparam logic [1:0] SEL_MID  = 2'd2;
   localparam logic [1:0] SEL_WIDE = 2'd3;

   localparam int F_SIZE_LO = 0;
   localparam int F_ONE     = 3;
   localparam int F_WAIT_LO = 4;
   localparam int F_RDY     = 6;

   typedef struct packed {
      logic [SIZE_W-1:0] size;
      logic [WAIT_W-1:0] wait_n;
      logic              rdy_req;
   } rgn_cfg_t;

   localparam rgn_cfg_t TOP_RESET = '{size: '0, wait_n: {WAIT_W{1'b1}}, rdy_req: 1'b1};

   function automatic rgn_cfg_t unpack_rgn(input logic [CFG_W-1:0] d);
      rgn_cfg_t r;
      r.size    = d[F_SIZE_LO +: SIZE_W];
      r.wait_n  = d[F_WAIT_LO +: WAIT_W];
      r.rdy_req = d[F_RDY];
      return r;
   endfunction

endpackage

// File: rtl/memsel_cfg.sv
module memsel_cfg
   import memsel_pkg::*;
#(
   parameter int BASE_W = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_sel,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output rgn_cfg_t             top_cfg,
   output rgn_cfg_t             bot_cfg,
   output rgn_cfg_t             mid_cfg,
   output logic                 bot_on,
   output logic                 mid_on,
   output logic                 mid_one,
   output logic [BASE_W-1:0]    mid_base,
   output logic                 bot_wide,
   output logic                 mid_wide
);

   localparam int BASE_LO = CFG_W - BASE_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_cfg  <= TOP_RESET;
         bot_cfg  <= '0;
         mid_cfg  <= '0;
         bot_on   <= 1'b0;
         mid_on   <= 1'b0;
         mid_one  <= 1'b0;
         mid_base <= '0;
         bot_wide <= 1'b0;
         mid_wide <= 1'b0;
      end else if (cfg_we) begin
         unique case (cfg_sel)
            SEL_TOP: top_cfg <= unpack_rgn(cfg_wdata);
            SEL_BOT: begin
               bot_cfg <= unpack_rgn(cfg_wdata);
               bot_on  <= 1'b1;
            end
            SEL_MID: begin
               mid_cfg  <= unpack_rgn(cfg_wdata);
               mid_on   <= 1'b1;
               mid_one  <= cfg_wdata[F_ONE];
               mid_base <= cfg_wdata[BASE_LO +: BASE_W];
            end
            SEL_WIDE: begin
               bot_wide <= cfg_wdata[0];
               mid_wide <= cfg_wdata[1];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/memsel_decode.sv
module memsel_decode
   import memsel_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int TOP_MIN_LOG2 = 16,
   parameter int BOT_MIN_LOG2 = 16,
   parameter int MID_MIN_LOG2 = 13
) (
   input  logic [ADDR_W-1:0]               addr,
   input  rgn_cfg_t                        top_cfg,
   input  rgn_cfg_t                        bot_cfg,
   input  rgn_cfg_t                        mid_cfg,
   input  logic                            bot_on,
   input  logic                            mid_on,
   input  logic                            mid_one,
   input  logic [ADDR_W-MID_MIN_LOG2-1:0]  mid_base,
   output logic [NSEL-1:0]                 hit_vec,
   output logic [WAIT_W-1:0]               wait_m,
   output logic                            req_m
);

   localparam int NRGN = 3;
   localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};

   logic [ADDR_W-1:0] top_mask, bot_mask, mid_mask, mid_full;
   logic              top_hit, bot_hit, mid_hit;
   logic [1:0]        quarter;
   logic [ADDR_W-1:0] shifted;
   logic [3:0]        mid_q;
   logic [NRGN-1:0]   rhit;
   rgn_cfg_t          rcfg [NRGN];

   always_comb begin
      top_mask = ONES << (TOP_MIN_LOG2 + int'(top_cfg.size));
      bot_mask = ONES << (BOT_MIN_LOG2 + int'(bot_cfg.size));
      mid_mask = ONES << (MID_MIN_LOG2 + int'(mid_cfg.size));
      mid_full = {mid_base, {MID_MIN_LOG2{1'b0}}};
      top_hit  = (addr & top_mask) == top_mask;
      bot_hit  = bot_on && ((addr & bot_mask) == '0);
      mid_hit  = mid_on && (((addr ^ mid_full) & mid_mask) == '0);
      shifted  = addr >> (MID_MIN_LOG2 - 2 + int'(mid_cfg.size));
      quarter  = mid_one ? 2'd0 : shifted[1:0];
   end

   for (genvar q = 0; q < 4; q++) begin : g_quarter
      assign mid_q[q] = mid_hit && (quarter == 2'(q));
   end

   // select priority: upper, then lower, then midrange
   assign hit_vec = {top_hit,
                     bot_hit & ~top_hit,
                     mid_q & {4{~top_hit & ~bot_hit}}};

   assign rhit = {mid_hit, bot_hit, top_hit};
   assign rcfg[0] = top_cfg;
   assign rcfg[1] = bot_cfg;
   assign rcfg[2] = mid_cfg;

   // every matching region constrains timing, whichever select wins
   always_comb begin
      wait_m = '0;
      req_m  = 1'b0;
      for (int i = 0; i < NRGN; i++) begin
         if (rhit[i]) begin
            if (rcfg[i].wait_n > wait_m) wait_m = rcfg[i].wait_n;
            req_m = req_m | rcfg[i].rdy_req;
         end
      end
   end

endmodule

// File: rtl/memsel_cycle.sv
module memsel_cycle
   import memsel_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NSEL-1:0]   hit_vec,
   input  logic [WAIT_W-1:0] wait_in,
   input  logic              req_in,
   input  logic              rdy_in,
   output logic [NSEL-1:0]   cs_n,
   output logic [WAIT_W-1:0] cyc_wait,
   output logic              cyc_rdy_req,
   output logic              cyc_done,
   output logic              busy
);

   typedef enum logic {ST_IDLE, ST_ACTIVE} cyc_state_t;

   cyc_state_t        state;
   logic [WAIT_W-1:0] cnt;

   assign busy     = (state == ST_ACTIVE);
   assign cyc_done = busy && (cnt == '0) && (!cyc_rdy_req || rdy_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         cs_n        <= '1;
         cyc_wait    <= '0;
         cyc_rdy_req <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state       <= ST_ACTIVE;
               cnt         <= wait_in;
               cyc_wait    <= wait_in;
               cyc_rdy_req <= req_in;
               cs_n        <= ~hit_vec;
            end
            ST_ACTIVE: begin
               if (cyc_done) begin
                  state <= ST_IDLE;
                  cs_n  <= '1;
               end else if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/memsel_unit.sv
module memsel_unit
   import memsel_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int TOP_MIN_LOG2 = 16,
   parameter int BOT_MIN_LOG2 = 16,
   parameter int MID_MIN_LOG2 = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [15:0]       cfg_wdata,
   input  logic              cyc_start,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic              rdy_in,
   output logic              top_cs_n,
   output logic              bot_cs_n,
   output logic [3:0]        mid_cs_n,
   output logic [1:0]        cyc_wait,
   output logic              cyc_rdy_req,
   output logic              cyc_done,
   output logic              bot_wide,
   output logic              mid_wide
);

   localparam int BASE_W   = ADDR_W - MID_MIN_LOG2;
   localparam int MAX_SIZE = (1 << SIZE_W) - 1;

   if (TOP_MIN_LOG2 + MAX_SIZE > ADDR_W) begin : g_bad_top
      $error("upper region can exceed the address space");
   end
   if (BOT_MIN_LOG2 + MAX_SIZE > ADDR_W) begin : g_bad_bot
      $error("lower region can exceed the address space");
   end
   if (MID_MIN_LOG2 < 2 || MID_MIN_LOG2 + MAX_SIZE > ADDR_W) begin : g_bad_mid
      $error("midrange block size out of range");
   end
   if (BASE_W > CFG_W - 8) begin : g_bad_base
      $error("midrange base field overlaps control bits");
   end

   rgn_cfg_t          top_cfg, bot_cfg, mid_cfg;
   logic              bot_on, mid_on, mid_one;
   logic [BASE_W-1:0] mid_base;
   logic [NSEL-1:0]   hit_vec, cs_n;
   logic [WAIT_W-1:0] wait_m;
   logic              req_m, busy;

   memsel_cfg #(.BASE_W(BASE_W)) u_cfg (
      .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
      .top_cfg, .bot_cfg, .mid_cfg, .bot_on, .mid_on, .mid_one, .mid_base,
      .bot_wide, .mid_wide
   );

   memsel_decode #(
      .ADDR_W(ADDR_W), .TOP_MIN_LOG2(TOP_MIN_LOG2),
      .BOT_MIN_LOG2(BOT_MIN_LOG2), .MID_MIN_LOG2(MID_MIN_LOG2)
   ) u_dec (
      .addr(cyc_addr), .top_cfg, .bot_cfg, .mid_cfg, .bot_on, .mid_on,
      .mid_one, .mid_base, .hit_vec, .wait_m, .req_m
   );

   memsel_cycle u_cyc (
      .clk, .rst_n, .start(cyc_start), .hit_vec, .wait_in(wait_m),
      .req_in(req_m), .rdy_in, .cs_n, .cyc_wait, .cyc_rdy_req, .cyc_done,
      .busy
   );

   assign top_cs_n = cs_n[5];
   assign bot_cs_n = cs_n[4];
   assign mid_cs_n = cs_n[3:0];

endmodule

// File: rtl/memsel_chk.sv
module memsel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       top_cs_n,
   input logic       bot_cs_n,
   input logic [3:0] mid_cs_n,
   input logic       cyc_start,
   input logic       cyc_done,
   input logic       cyc_rdy_req,
   input logic       rdy_in,
   input logic       busy,
   input logic       mid_one
);

   logic [5:0] csv;
   assign csv = {top_cs_n, bot_cs_n, mid_cs_n};

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~csv) <= 1); // R6
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |=> (csv == 6'h3F)); // R8
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (csv == 6'h3F)); // R8
   AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_done && cyc_rdy_req) |-> rdy_in); // R9
   AST_HOLD_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cyc_done) |=> $stable(csv)); // R11
   AST_SINGLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !busy && mid_one) |=> (&mid_cs_n[3:1])); // R5

endmodule

bind memsel_unit memsel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .top_cs_n(top_cs_n), .bot_cs_n(bot_cs_n),
   .mid_cs_n(mid_cs_n), .cyc_start(cyc_start), .cyc_done(cyc_done),
   .cyc_rdy_req(cyc_rdy_req), .rdy_in(rdy_in), .busy(busy), .mid_one(mid_one)
);

// File: tb/test_memsel_unit.sv
module test_memsel_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [15:0] cfg_wdata = '0;
   logic        cyc_start = 1'b0;
   logic [19:0] cyc_addr = '0;
   logic        rdy_in = 1'b1;
   logic        top_cs_n, bot_cs_n, cyc_rdy_req, cyc_done, bot_wide, mid_wide;
   logic [3:0]  mid_cs_n;
   logic [1:0]  cyc_wait;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   memsel_unit i_memsel_unit (
      .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .cyc_start, .cyc_addr,
      .rdy_in, .top_cs_n, .bot_cs_n, .mid_cs_n, .cyc_wait, .cyc_rdy_req,
      .cyc_done, .bot_wide, .mid_wide
   );

   // entry: {address, expected hits {top,bot,mid3..mid0}, wait, ready required}
   localparam logic [28:0] VEC [12] = '{
      {20'hF0000, 6'b100000, 2'd1, 1'b0},  // R2 upper, 128K
      {20'hE0000, 6'b100000, 2'd1, 1'b0},  // R2 lowest upper address
      {20'hDFFFF, 6'b000000, 2'd0, 1'b0},  // R12 just below upper
      {20'h00000, 6'b010000, 2'd2, 1'b0},  // R3 lower start
      {20'h0FFFF, 6'b010000, 2'd2, 1'b0},  // R3 lower end
      {20'h10000, 6'b000000, 2'd0, 1'b0},  // R12 above lower
      {20'h40000, 6'b000001, 2'd0, 1'b0},  // R4 quarter 0
      {20'h41000, 6'b000010, 2'd0, 1'b0},  // R4 quarter 1
      {20'h42FFF, 6'b000100, 2'd0, 1'b0},  // R4 quarter 2
      {20'h43FFF, 6'b001000, 2'd0, 1'b0},  // R4 quarter 3
      {20'h44000, 6'b000000, 2'd0, 1'b0},  // R12 above midrange
      {20'h3FFFF, 6'b000000, 2'd0, 1'b0}   // R12 below midrange
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic logic [5:0] hits();
      return ~{top_cs_n, bot_cs_n, mid_cs_n};
   endfunction

   // d: ready stays low for d clocks of the cycle; extra: second start mid-cycle
   task automatic do_cycle(input logic [19:0] a, input int d, input bit extra,
                           input logic [5:0] ehit, input int ew, input bit er,
                           input string req);
      int dur = 0;
      int exp_dur;
      bit stable = 1'b1;
      logic [5:0] first;
      exp_dur = (er && d > ew) ? d + 1 : ew + 1;
      @(negedge clk);
      cyc_start = 1'b1; cyc_addr = a; rdy_in = (d == 0);
      @(negedge clk);
      cyc_start = 1'b0;
      first = hits();
      chk(first == ehit, req, "selects", int'(first), int'(ehit));
      chk(int'(cyc_wait) == ew && cyc_rdy_req == er, req, "wait/ready",
          int'({cyc_wait, cyc_rdy_req}), ew * 2 + int'(er));
      forever begin
         dur++;
         if (dur > d) rdy_in = 1'b1;
         #1;
         if (hits() != first) stable = 1'b0;
         if (cyc_done || dur >= 60) break;
         if (extra && dur == 1) begin
            cyc_start = 1'b1; cyc_addr = a ^ 20'h80000;
         end
         @(negedge clk);
         cyc_start = 1'b0;
      end
      chk(dur == exp_dur, req, "cycle length", dur, exp_dur);
      chk(stable, req, "selects held during cycle", int'(stable), 1);
      @(negedge clk);
      cyc_start = 1'b0; rdy_in = 1'b1;
      chk(hits() == 6'b0, "R8", "selects released", int'(hits()), 0);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(hits() == 6'b0, "R1", "selects after reset", int'(hits()), 0);
      chk(!bot_wide && !mid_wide, "R1", "width flags", int'({bot_wide, mid_wide}), 0);
      do_cycle(20'hFFFF0, 0, 1'b0, 6'b100000, 3, 1'b1, "R1");
      do_cycle(20'hEFFFF, 0, 1'b0, 6'b000000, 0, 1'b0, "R1");
      // R9 ready held low past the count; R11 extra start ignored
      do_cycle(20'hF8000, 6, 1'b1, 6'b100000, 3, 1'b1, "R9");
      do_cycle(20'hF8000, 2, 1'b1, 6'b100000, 3, 1'b1, "R11");
      // R3 / R4 unprogrammed regions match nothing
      do_cycle(20'h00000, 0, 1'b0, 6'b000000, 0, 1'b0, "R3");
      do_cycle(20'h40000, 0, 1'b0, 6'b000000, 0, 1'b0, "R4");

      wr(2'd0, 16'h0011);
      wr(2'd1, 16'h0020);
      wr(2'd2, 16'h4001);
      for (int i = 0; i < 12; i++) begin
         logic [28:0] v;
         v = VEC[i];
         do_cycle(v[28:9], 0, 1'b0, v[8:3], int'(v[2:1]), v[0], "R4/R12 table");
      end

      // R2 largest upper region
      wr(2'd0, 16'h0003);
      do_cycle(20'h80000, 0, 1'b0, 6'b100000, 0, 1'b0, "R2");
      do_cycle(20'h7FFFF, 0, 1'b0, 6'b000000, 0, 1'b0, "R2");

      // R5 single-select midrange
      wr(2'd2, 16'h4009);
      do_cycle(20'h42000, 0, 1'b0, 6'b000001, 0, 1'b0, "R5");
      do_cycle(20'h43FFF, 0, 1'b0, 6'b000001, 0, 1'b0, "R5");

      // R6 / R7 slow midrange block inside the upper region
      wr(2'd0, 16'h0011);
      wr(2'd2, 16'hE070);
      do_cycle(20'hE0000, 0, 1'b0, 6'b100000, 3, 1'b1, "R7");
      do_cycle(20'hE1FFF, 4, 1'b0, 6'b100000, 3, 1'b1, "R6");
      do_cycle(20'hE2000, 0, 1'b0, 6'b100000, 1, 1'b0, "R7");

      // R10 width flags
      wr(2'd3, 16'h0003);
      @(negedge clk);
      chk(bot_wide && mid_wide, "R10", "both wide", int'({bot_wide, mid_wide}), 3);
      wr(2'd3, 16'h0002);
      @(negedge clk);
      chk(!bot_wide && mid_wide, "R10", "mid only wide", int'({bot_wide, mid_wide}), 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule